// File: doc/BRIEF.md
# Open-Drain Pin Pair Control Register

This block is the control and status word for one clock/data pin pair used when software bit-bangs a two-wire open-drain bus. Software writes one 32-bit word through a plain write strobe. Each pin has a direction field and a value field, and each of those fields has its own write-mask bit. A field is updated only when its mask bit is set in the same word. Software can therefore drive or release one pin without first reading the register back.

The block drives each pad's output enable and output data, and it also drives each pad's pull-up disable control. The pad inputs pass through a synchronizer into read-only bits. The two pull-up disable bits are plain storage that every write reloads, so software must carry them along in each word it writes.

To release a line, software sets direction to input with the direction mask set, and the external pull-up raises the line. To pull a line low, one write sets direction to drive, sets value to 0, and sets both masks. To sample a line, software writes the direction mask alone, then writes a word with no mask bits, then reads the input bit.

Top module: `pinpair_reg`

## Requirements
- R1: After reset, both pads are released with output enable 0, both output data bits are 0, both pull-up disable outputs are 0, and every stored bit reads back as 0.
- R2: A write with a lane's direction-mask bit set loads that lane's direction bit, where 1 means drive. The pad output enable equals the stored direction from the cycle after the write.
- R3: A write with a lane's direction-mask bit clear leaves that lane's direction unchanged, whatever the direction data bit holds.
- R4: A write with a lane's value-mask bit set loads that lane's value bit. The pad output data equals the stored value from the cycle after the write.
- R5: A write with a lane's value-mask bit clear leaves that lane's value unchanged, whatever the value data bit holds.
- R6: A single write that sets direction to 1 and value to 0, with both masks set, makes the pad drive low (output enable 1, output data 0) on the next cycle.
- R7: Every write loads both pull-up disable bits regardless of any mask. The bits drive the pad pull-up disable outputs and read back.
- R8: Each pad input reaches its read-only input bit two clock edges after it changes at the pad. Writes to the input bit have no effect on it.
- R9: A write that touches one lane's masks leaves the other lane's direction, value and pad outputs unchanged.
- R10: Word layout: the clock pin is lane 0 in bits 7:0 and the data pin is lane 1 in bits 15:8. Within a lane, bit 0 is the direction mask, bit 1 is direction, bit 2 is the value mask, bit 3 is value, bit 4 is input (read-only) and bit 5 is pull-up disable. Mask bits, lane bits 7:6 and word bits 31:16 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 32 | Write word |
| rd_data_o | output | 32 | Current register contents |
| pad_in_i | input | 2 | Pad input level, [0] clock, [1] data |
| pad_oe_o | output | 2 | Pad output enable, 1 drives |
| pad_out_o | output | 2 | Pad output data |
| pad_pu_dis_o | output | 2 | Pad pull-up disable |

## Verification
The bench writes words with the data bits set but the masks clear, and checks that direction and value hold. A design that ignored the masks would drive or release a pin by accident. The bench also writes masks in one lane only, which catches a lane-decode error that would disturb the other pin. It writes pull-up disable bits with no masks set, then writes a word with them cleared. A design that gated those bits by a mask, or kept them sticky, would show the wrong pad pull-up state. Finally, it changes a pad input and samples it one and two edges later, which catches a synchronizer that is too short or too long. It also writes the input and mask bit positions, which catches a design that makes them writable or reads the masks back.

// File: rtl/pinpair_pkg.sv
package pinpair_pkg;
  localparam int LANE_W  = 8;
  localparam int F_DMASK = 0;
  localparam int F_DIR   = 1;
  localparam int F_VMASK = 2;
  localparam int F_VAL   = 3;
  localparam int F_IN    = 4;
  localparam int F_PUD   = 5;

  typedef struct packed {
    logic dmask;
    logic dir;
    logic vmask;
    logic val;
    logic pud;
  } lane_wr_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pin_lane.sv
module pin_lane
  import pinpair_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  lane_wr_t wr_i,
  output logic     dir_o,
  output logic     val_o,
  output logic     pud_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= 1'b0;
      val_o <= 1'b0;
      pud_o <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_i.dmask) dir_o <= wr_i.dir;
      if (wr_i.vmask) val_o <= wr_i.val;
      pud_o <= wr_i.pud;   // unmasked: software re-supplies it every write
    end
  end

  a_r2_dir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_i.dmask) |=> (dir_o == $past(wr_i.dir)));
  a_r3_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_i.dmask) |=> $stable(dir_o));
  a_r4_val_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_i.vmask) |=> (val_o == $past(wr_i.val)));
  a_r5_val_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_i.vmask) |=> $stable(val_o));
  a_r7_pud_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (pud_o == $past(wr_i.pud)));
endmodule

// File: rtl/pinpair_reg.sv
module pinpair_reg
  import pinpair_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pu_dis_o
);
  localparam int USED_W = NUM_PINS * LANE_W;

  logic [NUM_PINS-1:0] dir_q, val_q, pud_q, in_s;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam int B = g * LANE_W;
    lane_wr_t lw;

    assign lw = '{dmask: wr_data_i[B+F_DMASK], dir: wr_data_i[B+F_DIR],
                  vmask: wr_data_i[B+F_VMASK], val: wr_data_i[B+F_VAL],
                  pud:   wr_data_i[B+F_PUD]};

    pin_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .wr_i    (lw),
      .dir_o   (dir_q[g]),
      .val_o   (val_q[g]),
      .pud_o   (pud_q[g])
    );

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pad_in_i[g]),
      .q_o    (in_s[g])
    );
  end

  assign pad_oe_o     = dir_q;
  assign pad_out_o    = val_q;
  assign pad_pu_dis_o = pud_q;

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      rd_data_o[p*LANE_W+F_DIR] = dir_q[p];
      rd_data_o[p*LANE_W+F_VAL] = val_q[p];
      rd_data_o[p*LANE_W+F_IN]  = in_s[p];
      rd_data_o[p*LANE_W+F_PUD] = pud_q[p];
    end
  end

  logic unused_wr;
  assign unused_wr = &{1'b0, wr_data_i};

  // R8: input bit moves only when the pad moved two edges earlier
  a_r8_in_from_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[F_IN] != $past(rd_data_o[F_IN])) |->
      (rd_data_o[F_IN] == $past(pad_in_i[0], 2)));
  // R10: mask positions never read back as set
  a_r10_mask_rd0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[F_DMASK] == 1'b0) && (rd_data_o[F_VMASK] == 1'b0) &&
    (rd_data_o[LANE_W+F_DMASK] == 1'b0) && (rd_data_o[LANE_W+F_VMASK] == 1'b0));
  initial begin
    a_r10_fits: assert (USED_W <= DATA_W);
  end
endmodule

// File: tb/sim_pinpair_reg.sv
`timescale 1ns/1ps
module sim_pinpair_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  pad_in = 2'b11;
  logic [1:0]  pad_oe, pad_out, pad_pud;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pinpair_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pad_in_i(pad_in), .pad_oe_o(pad_oe),
    .pad_out_o(pad_out), .pad_pu_dis_o(pad_pud)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, captured at posedge, observed at next negedge
  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 oe", {30'b0, pad_oe}, 32'h0);
    chk("R1 out", {30'b0, pad_out}, 32'h0);
    chk("R1 pud", {30'b0, pad_pud}, 32'h0);
    chk("R1 stored", rd_data & ~32'h1010, 32'h0);
  endtask

  task automatic t_pull_low;
    wr(32'h0000_0007);
    chk("R6 clk oe/out", {30'b0, pad_oe[0], pad_out[0]}, 32'h2);
    chk("R9 data lane idle", {30'b0, pad_oe[1], pad_out[1]}, 32'h0);
  endtask

  task automatic t_release;
    wr(32'h0000_0001);
    chk("R2 clk released", {31'b0, pad_oe[0]}, 32'h0);
    chk("R5 val kept", {31'b0, rd_data[3]}, 32'h0);
  endtask

  task automatic t_val_set;
    wr(32'h0000_000C);
    chk("R4 clk out", {31'b0, pad_out[0]}, 32'h1);
    chk("R3 dir kept", {31'b0, pad_oe[0]}, 32'h0);
  endtask

  task automatic t_no_mask;
    wr(32'h0000_0202);
    chk("R3 oe kept", {30'b0, pad_oe}, 32'h0);
    chk("R5 out kept", {30'b0, pad_out}, 32'h1);
    wr(32'h0000_0800);
    chk("R5 data val kept", {31'b0, pad_out[1]}, 32'h0);
  endtask

  task automatic t_data_lane;
    wr(32'h0000_0700);
    chk("R9 oe", {30'b0, pad_oe}, 32'h2);
    chk("R9 out", {30'b0, pad_out}, 32'h1);
  endtask

  task automatic t_pud;
    wr(32'h0000_2020);
    chk("R7 pud set", {30'b0, pad_pud}, 32'h3);
    chk("R7 rd", rd_data & 32'h2020, 32'h2020);
    chk("R7 no mask side effect", {28'b0, pad_oe, pad_out}, 32'h9);
    wr(32'h0000_0000);
    chk("R7 pud clear", {30'b0, pad_pud}, 32'h0);
  endtask

  task automatic t_input;
    chk("R8 settled", rd_data & 32'h1010, 32'h1010);
    @(negedge clk); pad_in = 2'b00;
    @(negedge clk);
    chk("R8 one edge", rd_data & 32'h1010, 32'h1010);
    @(negedge clk);
    chk("R8 two edges", rd_data & 32'h1010, 32'h0000);
    wr(32'h0000_1010);
    chk("R8 write ignored", rd_data & 32'h1010, 32'h0000);
    @(negedge clk); pad_in = 2'b10;
    repeat (2) @(negedge clk);
    chk("R8 data pin only", rd_data & 32'h1010, 32'h1000);
  endtask

  task automatic t_readback;
    wr(32'hFFFF_FFFF);
    chk("R10 layout", rd_data, 32'h0000_3A2A);
    chk("R10 pads", {26'b0, pad_oe, pad_out, pad_pud}, 32'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pull_low();
    t_release();
    t_val_set();
    t_no_mask();
    t_data_lane();
    t_pud();
    t_input();
    t_readback();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule